// File: doc/BRIEF.md
# Negated-Sum Adder

This block produces the two's-complement negation of the sum of two operands, -(A+B), without first forming A+B and then running the result through a separate negation step. It uses -(A+B) = ~A + ~B + 2. The constant is absorbed into a small dedicated stage that handles result bits 0 and 1. That stage passes a carry into a single ripple chain, which runs over the inverted upper operand bits. The result wraps modulo 2^WIDTH, and any carry beyond the top bit is dropped.

The carry leaving the two-bit stage can take the value 0, 1 or 2. The value 2 arises only when the low two bits of both operands are zero: the inverted pairs are then both 3, and 3 + 3 + 2 = 8. A one-bit carry would give a wrong answer in that case. The chain therefore passes a three-valued carry, held as a one-hot pair of wires.

The combinational result appears in the same cycle as the operands. A registered copy, qualified by a valid input, can be kept or removed with a parameter. The width parameter must be at least 3.

Top module: `negsum_adder`

## Requirements
- R1: For any operands, `neg_sum` equals (2^WIDTH - ((a_in + b_in) mod 2^WIDTH)) mod 2^WIDTH, in the same cycle, with no clock edge needed.
- R2: Bit 0 of `neg_sum` equals a_in[0] XOR b_in[0].
- R3: The result wraps modulo 2^WIDTH. Operands summing to zero give 0. The most-negative value (only the top bit set) plus 0 gives the most-negative value. The most-negative value plus itself gives 0.
- R4: When a_in[1:0] and b_in[1:0] are both 00, the result still equals -(A+B). This covers the case where the low stage carries the value 2 into the chain.
- R5: With both operands all ones, `neg_sum` equals 2.
- R6: After synchronous active-high reset, `neg_sum_q` is 0 and `out_valid_q` is 0.
- R7: When `in_valid` is 1 at a rising edge, `neg_sum_q` after that edge holds the `neg_sum` value present at the edge, and `out_valid_q` is 1.
- R8: When `in_valid` is 0 at a rising edge, `neg_sum_q` keeps its previous value and `out_valid_q` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid and should be captured |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| neg_sum | output | WIDTH | Combinational -(a_in+b_in) modulo 2^WIDTH |
| neg_sum_q | output | WIDTH | Registered copy of neg_sum, loaded when in_valid is 1 |
| out_valid_q | output | 1 | in_valid delayed by one cycle |

## Verification
The operand patterns fall into three groups.

The fixed corner pairs are zero, all ones and the most-negative value. They exercise the wrap at 2^WIDTH and the largest value the low stage can reach.

Operands with both low bit pairs cleared force the low stage to carry 2 into the chain. This pattern separates a correct three-valued carry from the one-bit shortcut, which is wrong only there.

Random operands with random valid gaps compare the combinational result and the registered copy each cycle against an integer model. These show whether capture, hold and the valid flag follow the input qualifier.

// File: rtl/negsum_pkg.sv
package negsum_pkg;

    // Carry between bit positions. Its value is 0, 1 or 2, and at most
    // one flag is set at a time.
    typedef struct packed {
        logic dbl;   // carry worth 2
        logic sgl;   // carry worth 1
    } tcarry_t;

    // Output of the two-bit low stage.
    typedef struct packed {
        logic [1:0] bits;
        tcarry_t    cout;
    } low_out_t;

    // Build a carry from the top bits of a column total.
    function automatic tcarry_t carry_from(input logic two, input logic one);
        tcarry_t c;
        c.dbl = two;
        c.sgl = one;
        return c;
    endfunction

endpackage

// File: rtl/negsum_low2.sv
module negsum_low2
    import negsum_pkg::*;
(
    input  logic [1:0] a_lo,
    input  logic [1:0] b_lo,
    output low_out_t   lo
);

    // Inverted low pairs plus the folded constant 2: the total lies in 2..8.
    logic [3:0] total;

    always_comb begin
        total   = {2'b00, ~a_lo} + {2'b00, ~b_lo} + 4'd2;
        lo.bits = total[1:0];
        lo.cout = carry_from(total[3], total[2]);
    end

endmodule

// File: rtl/negsum_upper.sv
module negsum_upper
    import negsum_pkg::*;
#(
    parameter int HI_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HI_W-1:0] a_hi,
    input  logic [HI_W-1:0] b_hi,
    input  tcarry_t         cin,
    output logic [HI_W-1:0] sum_hi
);

    tcarry_t carry [HI_W];

    assign carry[0] = cin;

    for (genvar i = 0; i < HI_W; i++) begin : g_cell
        if (i < HI_W - 1) begin : g_mid
            // Column total is 0..4, so the carry out is 0, 1 or 2.
            logic [2:0] tot;
            assign tot = {2'b00, ~a_hi[i]} + {2'b00, ~b_hi[i]}
                       + {2'b00, carry[i].sgl} + {1'b0, carry[i].dbl, 1'b0};
            assign sum_hi[i]  = tot[0];
            assign carry[i+1] = carry_from(tot[2], tot[1]);
        end else begin : g_top
            // Top column: only the parity matters; the carry out is dropped.
            assign sum_hi[i] = a_hi[i] ^ b_hi[i] ^ carry[i].sgl;
        end

        // R4: a carry entering any column holds at most one flag.
        a_r4_carry_onehot: assert property (@(posedge clk) disable iff (rst)
            $onehot0({carry[i].dbl, carry[i].sgl}));
    end

endmodule

// File: rtl/negsum_outreg.sv
module negsum_outreg #(
    parameter int WIDTH      = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             q_valid
);

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q       <= '0;
                q_valid <= 1'b0;
            end else begin
                if (in_valid) begin
                    q <= d;
                end
                q_valid <= in_valid;
            end
        end

        // R7: a valid input is captured and flagged on the next cycle.
        a_r7_capture: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (q_valid && q == $past(d)));

        // R8: without valid the copy holds and the flag drops.
        a_r8_hold: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!q_valid && $stable(q)));
    end else begin : g_pass
        assign q       = d;
        assign q_valid = in_valid;
    end

endmodule

// File: rtl/negsum_adder.sv
module negsum_adder
    import negsum_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] neg_sum,
    output logic [WIDTH-1:0] neg_sum_q,
    output logic             out_valid_q
);

    localparam int HI_W = WIDTH - 2;

    low_out_t        lo;
    logic [HI_W-1:0] sum_hi;

    negsum_low2 u_low (
        .a_lo (a_in[1:0]),
        .b_lo (b_in[1:0]),
        .lo   (lo)
    );

    negsum_upper #(.HI_W(HI_W)) u_upper (
        .clk    (clk),
        .rst    (rst),
        .a_hi   (a_in[WIDTH-1:2]),
        .b_hi   (b_in[WIDTH-1:2]),
        .cin    (lo.cout),
        .sum_hi (sum_hi)
    );

    assign neg_sum = {sum_hi, lo.bits};

    negsum_outreg #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (neg_sum),
        .q        (neg_sum_q),
        .q_valid  (out_valid_q)
    );

    // Adding the operands back to the result must give zero modulo 2^WIDTH.
    logic [WIDTH-1:0] cancel_chk;
    assign cancel_chk = neg_sum + a_in + b_in;

    // R1: the result cancels the operand sum.
    a_r1_sum_cancels: assert property (@(posedge clk) disable iff (rst)
        cancel_chk == '0);

    // R2: bit 0 of the result is the parity of the operand bits 0.
    a_r2_bit0_parity: assert property (@(posedge clk) disable iff (rst)
        neg_sum[0] == (a_in[0] ^ b_in[0]));

endmodule

// File: tb/negsum_adder_bench.sv
`timescale 1ns/1ps
module negsum_adder_bench;

    localparam int W = 16;
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] neg_sum;
    logic [W-1:0] neg_sum_q;
    logic         out_valid_q;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    negsum_adder #(.WIDTH(W), .REGISTERED(1'b1)) u_negsum_adder (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .a_in        (a_in),
        .b_in        (b_in),
        .neg_sum     (neg_sum),
        .neg_sum_q   (neg_sum_q),
        .out_valid_q (out_valid_q)
    );

    function automatic logic [W-1:0] ref_neg(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        r = '0 - a - b;
        return r;
    endfunction

    // Cycle model of the registered copy.
    logic [W-1:0] m_q = '0;
    logic         m_v = 1'b0;
    always @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
            m_v <= 1'b0;
        end else begin
            if (in_valid) m_q <= ref_neg(a_in, b_in);
            m_v <= in_valid;
        end
    end

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: check the registered copy, then drive and check the result.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic v, input string req);
        @(negedge clk);
        check(neg_sum_q == m_q, m_v ? "R7 copy" : "R8 copy", neg_sum_q, m_q);
        check(out_valid_q == m_v, m_v ? "R7 flag" : "R8 flag",
              W'(out_valid_q), W'(m_v));
        a_in = a;
        b_in = b;
        in_valid = v;
        #1;
        check(neg_sum == ref_neg(a, b), req, neg_sum, ref_neg(a, b));
        if (req == "R2")
            check(neg_sum[0] == (a[0] ^ b[0]), "R2 bit0",
                  W'(neg_sum[0]), W'(a[0] ^ b[0]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: state after reset, before any valid input.
        check(neg_sum_q == '0, "R6 copy", neg_sum_q, '0);
        check(out_valid_q == 1'b0, "R6 flag", W'(out_valid_q), '0);

        // R3 wrap corners
        step('0, '0, 1'b1, "R3");
        step(W'(1), ALL1, 1'b1, "R3");
        step(MINV, '0, 1'b1, "R3");
        step(MINV, MINV, 1'b1, "R3");
        // R5 all ones
        step(ALL1, ALL1, 1'b1, "R5");
        step(ALL1, ALL1, 1'b0, "R5");
        // R4 both low pairs zero
        step(W'(4), W'(8), 1'b1, "R4");
        step(MINV, W'(16'h4000), 1'b1, "R4");
        for (int i = 0; i < 24; i++)
            step(W'($urandom) & ~W'(3), W'($urandom) & ~W'(3),
                 1'($urandom), "R4");
        // R2 parity of bit 0
        for (int i = 0; i < 24; i++)
            step(W'($urandom), W'($urandom), 1'b1, "R2");
        // R8 hold: valid low for several cycles
        for (int i = 0; i < 6; i++)
            step(W'($urandom), W'($urandom), 1'b0, "R1");
        // R1 random with random valid gaps
        for (int i = 0; i < 300; i++)
            step(W'($urandom), W'($urandom), 1'($urandom), "R1");
        step('0, '0, 1'b0, "R1");
        step('0, '0, 1'b0, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule